// File: doc/BRIEF.md
# Parallel NOR Flash Command and Status Sequencer

This block is a synchronous model of the device side of a parallel NOR flash command port. Bus write cycles pass through a decoder that recognises the unlock handshake, the word-program and erase command chains, and an unlock-bypass mode. In that mode a word can be programmed with only two writes. An accepted program or erase starts a timed embedded operation on a small internal word array. Each sector of the array can be locked against change by a configuration input.

While an operation runs, the active-low busy output is held low. Every read cycle returns a polling status word instead of array data. A program or erase aimed at locked sectors still produces a busy window of fixed length, then leaves the array as it was. All delays are cycle counts. The defaults give 1 µs and 100 µs protected windows at a 250 MHz clock. Reads are registered: the word appears on `dout` the cycle after `rd_en` is sampled.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `busy_n` is 1, `dout` is 00h, every array word reads FFh and the device is in normal (not bypass) mode.
- R2: The write chain AAh@15h, 55h@2Ah, A0h@15h followed by one write (address, data) programs that word. The unlock addresses are the low 6 address bits of 555h and 2AAh. The new word is the old word AND the written data.
- R3: An accepted command drives `busy_n` low from the clock edge that captures its final write. It stays low for exactly PROG_CYC cycles for a program and ERASE_CYC cycles for an erase.
- R4: A read while busy returns a status word. For a program, bit 7 is the inverse of data bit 7 and bits 6:0 are 0. For an erase, the status word is 00h. Once the operation ends, reads return the array word.
- R5: AAh@15h, 55h@2Ah, 80h@15h, AAh@15h, 55h@2Ah, then 30h at any address erases the sector given by address bits 5:4. Every word of that sector becomes FFh.
- R6: The same chain ending in 10h@15h erases every sector whose `sect_lock` bit is 0 and leaves locked sectors unchanged.
- R7: A program into a locked sector holds `busy_n` low for PPROT_CYC cycles and leaves the word unchanged.
- R8: An erase whose selected sectors are all locked holds `busy_n` low for EPROT_CYC cycles and changes nothing.
- R9: AAh@15h, 55h@2Ah, 20h@15h enters bypass mode. In bypass mode, A0h at any address followed by (address, data) programs a word, and the device stays in bypass mode.
- R10: In bypass mode, every write other than the bypass program and exit chains is ignored, including F0h and the full unlock and erase chain. No busy window starts and the array is unchanged.
- R11: In bypass mode, 90h then 00h, at any addresses, returns the device to normal mode. After that, a bare A0h plus a data write programs nothing.
- R12: Writes made while busy are ignored. They neither extend the busy window nor change the array.
- R13: A write that breaks an unlock chain (wrong data or address) returns the decoder to read mode, so the writes that follow cannot complete the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe, one cycle per read |
| addr | input | ADDR_W | Word address for reads and writes |
| din | input | 8 | Write data / command byte |
| sect_lock | input | NUM_SECT | Per-sector protect bits, 1 = locked |
| dout | output | 8 | Registered read data or polling status |
| busy_n | output | 1 | Low while an embedded operation runs |

## Verification
Programs are tried with data whose bit 7 is 0 and with data whose bit 7 is 1, so the polling bit shows its inversion in both directions. A second program over an already written word separates AND-merging from overwriting. Erases are run once on a single sector and once on the whole chip with one sector locked, which shows that locked sectors are skipped. Programs and erases aimed only at locked sectors are checked by the exact length of the busy window and by the unchanged contents afterwards. Broken chains, writes during busy, stray writes in bypass mode and a bare program after bypass exit are each followed by a read-back and a busy-window count of zero or of the unextended length.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [0:0] {OP_PROG = 1'b0, OP_ERASE = 1'b1} op_kind_t;

  // command bytes
  localparam byte_t CMD_KEY1      = 8'hAA;
  localparam byte_t CMD_KEY2      = 8'h55;
  localparam byte_t CMD_PROG      = 8'hA0;
  localparam byte_t CMD_ERS_SETUP = 8'h80;
  localparam byte_t CMD_BYP_ENTER = 8'h20;
  localparam byte_t CMD_ERS_CHIP  = 8'h10;
  localparam byte_t CMD_ERS_SECT  = 8'h30;
  localparam byte_t CMD_BYP_EXIT1 = 8'h90;
  localparam byte_t CMD_BYP_EXIT2 = 8'h00;

  // full-width unlock addresses, truncated to the array address width
  localparam logic [15:0] KEY1_ADDR_FULL = 16'h0555;
  localparam logic [15:0] KEY2_ADDR_FULL = 16'h02AA;

  // programming can only clear bits
  function automatic byte_t prog_merge(byte_t old_w, byte_t wr_w);
    return old_w & wr_w;
  endfunction

  // polling word returned by reads while busy
  function automatic byte_t poll_word(op_kind_t k, byte_t d);
    byte_t s;
    s = '0;
    if (k == OP_PROG) s[BYTE_W-1] = ~d[BYTE_W-1];
    return s;
  endfunction

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/nor_cmd_decode.sv
module nor_cmd_decode
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int NUM_SECT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                busy,
  input  logic [ADDR_W-1:0]   addr,
  input  byte_t               din,
  output logic                cmd_valid,
  output op_kind_t            cmd_kind,
  output logic [ADDR_W-1:0]   cmd_addr,
  output byte_t               cmd_data,
  output logic [NUM_SECT-1:0] cmd_sel
);
  localparam int SECT_W = $clog2(NUM_SECT);
  localparam logic [ADDR_W-1:0] KEY1_A = ADDR_W'(KEY1_ADDR_FULL);
  localparam logic [ADDR_W-1:0] KEY2_A = ADDR_W'(KEY2_ADDR_FULL);

  typedef enum logic [3:0] {
    ST_READ, ST_KEY1, ST_KEY2, ST_PGM_DATA,
    ST_ERS_A, ST_ERS_B, ST_ERS_C,
    ST_BYP, ST_BYP_DATA, ST_BYP_EXIT
  } dec_state_t;

  dec_state_t st, nxt;

  // named decode events
  logic acc_wr;
  logic hit_key1, hit_key2, hit_prog, hit_ers, hit_byp, hit_chip;
  logic hit_sect, hit_bprog, hit_bx1, hit_bx2;
  logic in_bypass;

  assign acc_wr    = wr_en & ~busy;
  assign hit_key1  = (din == CMD_KEY1)      && (addr == KEY1_A);
  assign hit_key2  = (din == CMD_KEY2)      && (addr == KEY2_A);
  assign hit_prog  = (din == CMD_PROG)      && (addr == KEY1_A);
  assign hit_ers   = (din == CMD_ERS_SETUP) && (addr == KEY1_A);
  assign hit_byp   = (din == CMD_BYP_ENTER) && (addr == KEY1_A);
  assign hit_chip  = (din == CMD_ERS_CHIP)  && (addr == KEY1_A);
  assign hit_sect  = (din == CMD_ERS_SECT);
  assign hit_bprog = (din == CMD_PROG);
  assign hit_bx1   = (din == CMD_BYP_EXIT1);
  assign hit_bx2   = (din == CMD_BYP_EXIT2);
  assign in_bypass = (st == ST_BYP) || (st == ST_BYP_DATA) || (st == ST_BYP_EXIT);

  assign cmd_addr = addr;
  assign cmd_data = din;

  always_comb begin
    nxt       = st;
    cmd_valid = 1'b0;
    cmd_kind  = OP_PROG;
    cmd_sel   = '0;
    if (acc_wr) begin
      case (st)
        ST_READ:     if (hit_key1) nxt = ST_KEY1;
        ST_KEY1:     nxt = hit_key2 ? ST_KEY2 : ST_READ;
        ST_KEY2: begin
          if (hit_prog)     nxt = ST_PGM_DATA;
          else if (hit_ers) nxt = ST_ERS_A;
          else if (hit_byp) nxt = ST_BYP;
          else              nxt = ST_READ;
        end
        ST_PGM_DATA: begin
          cmd_valid = 1'b1;
          nxt       = ST_READ;
        end
        ST_ERS_A:    nxt = hit_key1 ? ST_ERS_B : ST_READ;
        ST_ERS_B:    nxt = hit_key2 ? ST_ERS_C : ST_READ;
        ST_ERS_C: begin
          nxt = ST_READ;
          if (hit_chip) begin
            cmd_valid = 1'b1;
            cmd_kind  = OP_ERASE;
            cmd_sel   = '1;
          end else if (hit_sect) begin
            cmd_valid = 1'b1;
            cmd_kind  = OP_ERASE;
            cmd_sel[addr[ADDR_W-1 -: SECT_W]] = 1'b1;
          end
        end
        ST_BYP: begin
          if (hit_bprog)    nxt = ST_BYP_DATA;
          else if (hit_bx1) nxt = ST_BYP_EXIT;
        end
        ST_BYP_DATA: begin
          cmd_valid = 1'b1;
          nxt       = ST_BYP;
        end
        ST_BYP_EXIT: nxt = hit_bx2 ? ST_READ : ST_BYP;
        default:     nxt = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_READ;
    else        st <= nxt;
  end

  // bypass mode is only left through an accepted exit byte
  assert_bypass_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_bypass) |-> $past(acc_wr && hit_bx2));

  // no erase can be launched from bypass mode
  assert_bypass_prog_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bypass && cmd_valid) |-> (cmd_kind == OP_PROG));

endmodule

// File: rtl/nor_op_engine.sv
module nor_op_engine
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int NUM_SECT   = 4,
  parameter int PROG_CYC   = 40,
  parameter int ERASE_CYC  = 300,
  parameter int PPROT_CYC  = 250,
  parameter int EPROT_CYC  = 25000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  op_kind_t            cmd_kind,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  byte_t               cmd_data,
  input  logic [NUM_SECT-1:0] cmd_sel,
  input  logic [NUM_SECT-1:0] sect_lock,
  output logic                busy,
  output logic                op_done,
  output op_kind_t            op_kind,
  output logic [ADDR_W-1:0]   op_addr,
  output byte_t               op_data,
  output logic [NUM_SECT-1:0] op_mask,
  output logic                op_blocked,
  output byte_t               status
);
  localparam int SECT_W  = $clog2(NUM_SECT);
  localparam int MAX_CYC = max4(PROG_CYC, ERASE_CYC, PPROT_CYC, EPROT_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0]    cnt, run_len, len_q;
  logic [NUM_SECT-1:0] eff_sel;
  logic                blk_new;
  logic [CNT_W-1:0]    len_new;
  logic                start;

  function automatic logic [CNT_W-1:0] op_len(op_kind_t k, logic blk);
    if (k == OP_PROG) return blk ? CNT_W'(PPROT_CYC) : CNT_W'(PROG_CYC);
    return blk ? CNT_W'(EPROT_CYC) : CNT_W'(ERASE_CYC);
  endfunction

  assign start   = cmd_valid && !busy;
  assign eff_sel = cmd_sel & ~sect_lock;
  assign blk_new = (cmd_kind == OP_PROG) ? sect_lock[cmd_addr[ADDR_W-1 -: SECT_W]]
                                         : (eff_sel == '0);
  assign len_new = op_len(cmd_kind, blk_new);
  assign op_done = busy && (cnt == '0);
  assign status  = poll_word(op_kind, op_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cnt        <= '0;
      run_len    <= '0;
      len_q      <= '0;
      op_kind    <= OP_PROG;
      op_addr    <= '0;
      op_data    <= '0;
      op_mask    <= '0;
      op_blocked <= 1'b0;
    end else if (start) begin
      busy       <= 1'b1;
      cnt        <= len_new - 1'b1;
      len_q      <= len_new;
      run_len    <= '0;
      op_kind    <= cmd_kind;
      op_addr    <= cmd_addr;
      op_data    <= cmd_data;
      op_mask    <= (cmd_kind == OP_ERASE) ? eff_sel : '0;
      op_blocked <= blk_new;
    end else if (busy) begin
      run_len <= run_len + 1'b1;
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // the decoder must not launch anything while an operation runs
  assert_no_cmd_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_valid);

  // busy only rises because a command was accepted
  assert_busy_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  // the last counted cycle ends the window
  assert_busy_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !busy);

  // the window never outlasts its programmed length
  assert_busy_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < len_q));

endmodule

// File: rtl/nor_array.sv
module nor_array
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int NUM_SECT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic                busy,
  input  byte_t               status,
  input  logic                op_done,
  input  op_kind_t            op_kind,
  input  logic [ADDR_W-1:0]   op_addr,
  input  byte_t               op_data,
  input  logic [NUM_SECT-1:0] op_mask,
  input  logic                op_blocked,
  output byte_t               dout
);
  localparam int WORDS  = 1 << ADDR_W;
  localparam int SECT_W = $clog2(NUM_SECT);
  localparam int SHIFT  = ADDR_W - SECT_W;

  byte_t            mem [WORDS];
  logic [WORDS-1:0] word_erase;
  logic             commit_prog, commit_erase;

  for (genvar w = 0; w < WORDS; w++) begin : g_erase_map
    assign word_erase[w] = op_mask[SECT_W'(w >> SHIFT)];
  end

  assign commit_prog  = op_done && !op_blocked && (op_kind == OP_PROG);
  assign commit_erase = op_done && (op_kind == OP_ERASE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem[ADDR_W'(w)] <= '1;
    end else if (commit_prog) begin
      mem[op_addr] <= prog_merge(mem[op_addr], op_data);
    end else if (commit_erase) begin
      for (int w = 0; w < WORDS; w++)
        if (word_erase[ADDR_W'(w)]) mem[ADDR_W'(w)] <= '1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     dout <= '0;
    else if (rd_en) dout <= busy ? status : mem[rd_addr];
  end

  // a program may clear bits but never set one
  assert_prog_clears_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && op_kind == OP_PROG) |=> ((mem[op_addr] & ~$past(mem[op_addr])) == '0));

  // a locked program leaves its word untouched
  assert_locked_prog_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && op_blocked && op_kind == OP_PROG) |=> (mem[op_addr] == $past(mem[op_addr])));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_SECT  = 4,
  parameter int CLK_MHZ   = 250,
  parameter int PROG_CYC  = 40,
  parameter int ERASE_CYC = 300,
  parameter int PPROT_CYC = CLK_MHZ,
  parameter int EPROT_CYC = CLK_MHZ * 100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          din,
  input  logic [NUM_SECT-1:0] sect_lock,
  output logic [7:0]          dout,
  output logic                busy_n
);
  logic                cmd_valid, busy, op_done, op_blocked;
  op_kind_t            cmd_kind, op_kind;
  logic [ADDR_W-1:0]   cmd_addr, op_addr;
  byte_t               cmd_data, op_data, status;
  logic [NUM_SECT-1:0] cmd_sel, op_mask;

  nor_cmd_decode #(.ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy), .addr(addr), .din(din),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_sel(cmd_sel)
  );

  nor_op_engine #(
    .ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT), .PROG_CYC(PROG_CYC),
    .ERASE_CYC(ERASE_CYC), .PPROT_CYC(PPROT_CYC), .EPROT_CYC(EPROT_CYC)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_sel(cmd_sel), .sect_lock(sect_lock),
    .busy(busy), .op_done(op_done), .op_kind(op_kind), .op_addr(op_addr),
    .op_data(op_data), .op_mask(op_mask), .op_blocked(op_blocked), .status(status)
  );

  nor_array #(.ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT)) u_arr (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(addr), .busy(busy),
    .status(status), .op_done(op_done), .op_kind(op_kind), .op_addr(op_addr),
    .op_data(op_data), .op_mask(op_mask), .op_blocked(op_blocked), .dout(dout)
  );

  assign busy_n = ~busy;

  // reads during an operation never expose a set bit 6..0
  assert_status_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_en) && $past(busy)) |-> (dout[6:0] == 7'd0));

endmodule

// File: tb/tb_nor_cmd_seq.sv
`timescale 1ns/1ps
module tb_nor_cmd_seq;
  localparam int AW    = 6;
  localparam int NS    = 4;
  localparam int PROG  = 40;
  localparam int ERASE = 300;
  localparam int PPROT = 250;
  localparam int EPROT = 25000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [NS-1:0] sect_lock = '0;
  logic [7:0]    dout;
  logic          busy_n;

  int checks = 0;
  int fails  = 0;
  int low_cnt = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  nor_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .din(din), .sect_lock(sect_lock), .dout(dout), .busy_n(busy_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // busy-window length, counted at falling edges
  always @(negedge clk) if (!busy_n) low_cnt++;

  // scoreboard monitor: one expected word per read
  always begin
    @(posedge clk);
    if (rd_en) begin
      logic [7:0] e;
      string t;
      #1;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(dout == e, t, dout, e);
    end
  end

  // driver tasks start and end on a falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    addr = a; din = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (!busy_n) @(negedge clk);
  endtask

  task automatic unlock();
    wr(6'h15, 8'hAA);
    wr(6'h2A, 8'h55);
  endtask

  task automatic std_prog(input logic [AW-1:0] a, input logic [7:0] d);
    unlock();
    wr(6'h15, 8'hA0);
    wr(a, d);
  endtask

  task automatic erase_pre();
    unlock();
    wr(6'h15, 8'h80);
    unlock();
  endtask

  task automatic window(input int exp, input string tag);
    wait_idle();
    check(low_cnt == exp, tag, low_cnt, exp);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(busy_n == 1'b1, "R1 busy_n after reset", busy_n, 1);
    check(dout == 8'h00, "R1 dout after reset", dout, 0);
    rd(6'h00, 8'hFF, "R1 word 00 erased");
    rd(6'h3F, 8'hFF, "R1 word 3F erased");

    // R2/R3/R4 program, data bit7 = 0
    low_cnt = 0;
    std_prog(6'h03, 8'h5A);
    rd(6'h03, 8'h80, "R4 program status inverts bit7=0");
    window(PROG, "R3 program busy length");
    rd(6'h03, 8'h5A, "R2 programmed word");

    // R2 AND merge, R12 writes during busy ignored
    low_cnt = 0;
    std_prog(6'h03, 8'h0F);
    rd(6'h03, 8'h80, "R4 status during second program");
    std_prog(6'h05, 8'h00);
    window(PROG, "R12 busy window not extended");
    rd(6'h03, 8'h0A, "R2 AND merge");
    rd(6'h05, 8'hFF, "R12 write while busy ignored");

    // R4 program, data bit7 = 1
    low_cnt = 0;
    std_prog(6'h04, 8'h80);
    rd(6'h04, 8'h00, "R4 program status inverts bit7=1");
    window(PROG, "R3 program busy length 2");
    rd(6'h04, 8'h80, "R4 true data after program");

    // R5 sector erase of sector 0
    low_cnt = 0;
    erase_pre();
    wr(6'h05, 8'h30);
    rd(6'h05, 8'h00, "R4 erase status");
    window(ERASE, "R5 erase busy length");
    rd(6'h03, 8'hFF, "R5 sector word 03 erased");
    rd(6'h04, 8'hFF, "R5 sector word 04 erased");

    // R6 chip erase with sector 1 locked
    std_prog(6'h12, 8'h33); wait_idle();
    std_prog(6'h22, 8'h44); wait_idle();
    sect_lock = 4'b0010;
    low_cnt = 0;
    erase_pre();
    wr(6'h15, 8'h10);
    window(ERASE, "R6 chip erase busy length");
    rd(6'h12, 8'h33, "R6 locked sector kept");
    rd(6'h22, 8'hFF, "R6 unlocked sector erased");

    // R7 program into locked sector
    low_cnt = 0;
    std_prog(6'h13, 8'h00);
    rd(6'h13, 8'h80, "R7 locked program status");
    window(PPROT, "R7 locked program busy length");
    rd(6'h13, 8'hFF, "R7 locked word unchanged");

    // R8 erase of a locked sector only
    low_cnt = 0;
    erase_pre();
    wr(6'h10, 8'h30);
    window(EPROT, "R8 locked erase busy length");
    rd(6'h12, 8'h33, "R8 locked sector unchanged");
    sect_lock = '0;

    // R13 broken chain
    low_cnt = 0;
    wr(6'h15, 8'hAA);
    wr(6'h2A, 8'h56);
    wr(6'h15, 8'hA0);
    wr(6'h20, 8'h00);
    @(negedge clk);
    check(low_cnt == 0, "R13 no busy after broken chain", low_cnt, 0);
    rd(6'h20, 8'hFF, "R13 word not programmed");

    // R9 bypass enter and two-write program
    unlock();
    wr(6'h15, 8'h20);
    low_cnt = 0;
    wr(6'h00, 8'hA0);
    wr(6'h30, 8'h3C);
    window(PROG, "R9 bypass program busy length");
    rd(6'h30, 8'h3C, "R9 bypass programmed word");

    // R10 stray writes in bypass ignored
    low_cnt = 0;
    erase_pre();
    wr(6'h30, 8'h30);
    wr(6'h00, 8'hF0);
    @(negedge clk);
    check(low_cnt == 0, "R10 no busy from stray writes", low_cnt, 0);
    rd(6'h30, 8'h3C, "R10 array unchanged in bypass");
    low_cnt = 0;
    wr(6'h01, 8'hA0);
    wr(6'h32, 8'h11);
    window(PROG, "R10 still in bypass after F0");
    rd(6'h32, 8'h11, "R10 bypass program after F0");

    // R11 exit bypass
    wr(6'h07, 8'h90);
    wr(6'h3F, 8'h00);
    low_cnt = 0;
    wr(6'h00, 8'hA0);
    wr(6'h31, 8'h00);
    @(negedge clk);
    check(low_cnt == 0, "R11 bare program after exit no busy", low_cnt, 0);
    rd(6'h31, 8'hFF, "R11 bare program ignored");
    std_prog(6'h31, 8'h0F);
    wait_idle();
    rd(6'h31, 8'h0F, "R11 normal program after exit");

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule